// File: doc/BRIEF.md
# Multi-Gate Hardware Semaphore Bank

This block holds a row of hardware lock gates that several bus masters share to coordinate access to common resources. Each gate is one byte. A master claims a gate by writing its own index plus one into the gate's owner field. The gate accepts that claim only while it is free, and on success it also records the writer's domain tag. The master then reads the gate back to learn whether the claim took hold. Only the owner can free a gate, which it does by writing an owner value of zero.

A separate forced-release register lets software recover gates whose owner has died. It uses a two-write key sequence. The first write arms the sequence. The second write carries the completion pattern and a gate number, and clears either that one gate or, for a number at or above the gate count, every gate at once.

Each master has its own write port carrying the index, data and domain side-band. All masters share one combinational read port. The write ports have no back-pressure: a write is taken in the cycle its enable is high, so there is no ready signal. Whether a write has effect is learned only by reading back.

Top module: `sema_bank`

## Requirements
- R1: After reset every gate reads 0x00 and the forced-release state reads 0.
- R2: A gate byte holds the owner field in bits [3:0], the domain in bits [5:4] and zeros in bits [7:6]. A write by master m whose bits [3:0] equal m+1 to a free gate (owner 0) makes the gate read {2'b00, domain, m+1} from the next cycle.
- R3: A write to a gate owned by a different master, either a claim or an owner-zero write, leaves the gate unchanged.
- R4: A write with owner field 0 by the owning master frees the gate, so it reads 0x00.
- R5: A claim whose bits [3:0] are neither 0 nor the writer's index plus one is ignored. Write bits [7:4] are ignored for both claims and releases.
- R6: When several masters write the same gate in one cycle, all of them are judged against the gate's old value, and the lowest-indexed successful writer decides the result.
- R7: A forced-release write (release-select high) of 0xE2 followed by one of 0x1D with gate number below 64 clears only that gate.
- R8: If the second forced-release write carries a gate number of 64 or more (7-bit number), every gate is cleared.
- R9: The forced-release state output reads 1 in the cycles after an accepted 0xE2 write and 0 otherwise, including right after the 0x1D write.
- R10: While armed, any write that is not the 0x1D completion returns the state to 0 and clears no gate. This covers a wrong pattern, a second 0xE2, or any gate write. A 0x1D write while idle does nothing.
- R11: When a completion and a gate write land in the same cycle, the clearing wins on the targeted gate(s), and writes to other gates take effect.
- R12: A gate write (release-select low) with gate number 64 or more changes no gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_wen | input | NUM_MASTERS | Per-master write enable |
| m_rsel | input | NUM_MASTERS | Per-master select of the forced-release register instead of a gate |
| m_addr | input | NUM_MASTERS x 7 | Per-master gate number, also the target of a forced release |
| m_wdata | input | NUM_MASTERS x 8 | Per-master write byte |
| m_dom | input | NUM_MASTERS x 2 | Per-master domain tag side-band |
| rd_addr | input | 6 | Gate selected on the read port |
| rd_data | output | 8 | Byte of the selected gate |
| rst_state | output | 2 | Forced-release sequence state, 0 idle, 1 armed |

## Verification
Two functions can hit the same gate in one cycle. One is the completion of a forced release. The other is an ordinary claim or release, and a claim race between masters can occur in that same cycle. A directed cycle places a 0x1D completion on one master and a claim of the targeted gate plus a claim of a neighbouring gate on others. The test expects the targeted gate to read zero and the neighbour to be owned. Random traffic focused on eight gates keeps producing same-cycle races and collisions. Each result is judged against a bench model that checks candidate writes in ascending master order against the old gate value and applies the clear last.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // gate byte layout: neighbours decode these bit positions
  localparam int OWN_W = 4;
  localparam int DOM_W = 2;
  localparam logic [7:0] PAT_ARM  = 8'hE2;
  localparam logic [7:0] PAT_FIRE = 8'h1D;

  typedef struct packed {
    logic [1:0]       pad;
    logic [DOM_W-1:0] dom;
    logic [OWN_W-1:0] owner;
  } gate_t;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_ARMED = 2'd1
  } rst_st_e;
endpackage

// File: rtl/sema_gate.sv
module sema_gate
  import sema_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_MASTERS-1:0]                hit,
  input  logic [NUM_MASTERS-1:0][OWN_W-1:0]     wfield,
  input  logic [NUM_MASTERS-1:0][DOM_W-1:0]     wdom,
  input  logic                                  clear,
  output gate_t                                 gate_q
);

  gate_t nxt;

  // Every candidate is judged against the old value; the loop runs from the
  // highest index down so the lowest successful master is assigned last.
  always_comb begin
    nxt = gate_q;
    for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
      if (hit[m]) begin
        if (gate_q.owner == '0 && wfield[m] == OWN_W'(m + 1)) begin
          nxt.owner = wfield[m];
          nxt.dom   = wdom[m];
          nxt.pad   = '0;
        end else if (gate_q.owner == OWN_W'(m + 1) && wfield[m] == '0) begin
          nxt = '0;
        end
      end
    end
    if (clear) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= nxt;
  end

  AST_OWNED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q.owner != '0 && !clear) |=> (gate_q.owner == $past(gate_q.owner) || gate_q.owner == '0)); // R3

  AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (gate_q == '0)); // R7

endmodule

// File: rtl/sema_rst_ctl.sv
module sema_rst_ctl
  import sema_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_GATES   = 64,
  parameter int GIDX_W      = $clog2(NUM_GATES),
  parameter int ADDR_W      = GIDX_W + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_MASTERS-1:0]            wen,
  input  logic [NUM_MASTERS-1:0]            rsel,
  input  logic [NUM_MASTERS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_MASTERS-1:0][7:0]       wdata,
  output rst_st_e                           st_q,
  output logic                              fire,
  output logic                              fire_all,
  output logic [GIDX_W-1:0]                 fire_idx
);

  logic              sel_v;
  logic [7:0]        sel_data;
  logic [ADDR_W-1:0] sel_addr;
  rst_st_e           st_d;

  // lowest-indexed master writing the forced-release register
  always_comb begin
    sel_v    = 1'b0;
    sel_data = '0;
    sel_addr = '0;
    for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
      if (wen[m] && rsel[m]) begin
        sel_v    = 1'b1;
        sel_data = wdata[m];
        sel_addr = addr[m];
      end
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      RS_IDLE: if (sel_v && sel_data == PAT_ARM) st_d = RS_ARMED;
      default: if (|wen) st_d = RS_IDLE;
    endcase
  end

  assign fire     = (st_q == RS_ARMED) && sel_v && (sel_data == PAT_FIRE);
  assign fire_all = (sel_addr >= ADDR_W'(NUM_GATES));
  assign fire_idx = sel_addr[GIDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_ARMED && $past(st_q) == RS_IDLE) |-> $past(sel_v && sel_data == PAT_ARM)); // R9

  AST_ARMED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_ARMED && |wen) |=> (st_q == RS_IDLE)); // R10

endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int NUM_MASTERS = 4,   // at most 15: owner field holds index plus one
  parameter int NUM_GATES   = 64,
  localparam int GIDX_W     = $clog2(NUM_GATES),
  localparam int ADDR_W     = GIDX_W + 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_MASTERS-1:0]             m_wen,
  input  logic [NUM_MASTERS-1:0]             m_rsel,
  input  logic [NUM_MASTERS-1:0][ADDR_W-1:0] m_addr,
  input  logic [NUM_MASTERS-1:0][7:0]        m_wdata,
  input  logic [NUM_MASTERS-1:0][DOM_W-1:0]  m_dom,
  input  logic [GIDX_W-1:0]                  rd_addr,
  output logic [7:0]                         rd_data,
  output logic [1:0]                         rst_state
);

  rst_st_e           st;
  logic              fire;
  logic              fire_all;
  logic [GIDX_W-1:0] fire_idx;
  logic [NUM_GATES-1:0] clr_vec;
  gate_t             gates [NUM_GATES];

  sema_rst_ctl #(
    .NUM_MASTERS (NUM_MASTERS),
    .NUM_GATES   (NUM_GATES),
    .GIDX_W      (GIDX_W),
    .ADDR_W      (ADDR_W)
  ) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .wen      (m_wen),
    .rsel     (m_rsel),
    .addr     (m_addr),
    .wdata    (m_wdata),
    .st_q     (st),
    .fire     (fire),
    .fire_all (fire_all),
    .fire_idx (fire_idx)
  );

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic [NUM_MASTERS-1:0]            hit;
    logic [NUM_MASTERS-1:0][OWN_W-1:0] fld;

    // full-width compare: gate numbers at or above the count match nothing
    always_comb begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
        hit[m] = m_wen[m] && !m_rsel[m] && (m_addr[m] == ADDR_W'(g));
        fld[m] = m_wdata[m][OWN_W-1:0];
      end
    end

    assign clr_vec[g] = fire && (fire_all || fire_idx == GIDX_W'(g));

    sema_gate #(.NUM_MASTERS(NUM_MASTERS)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit),
      .wfield (fld),
      .wdom   (m_dom),
      .clear  (clr_vec[g]),
      .gate_q (gates[g])
    );
  end

  assign rd_data   = gates[rd_addr];
  assign rst_state = st;

  AST_CLR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(clr_vec) || (&clr_vec))); // R8

  AST_FIRE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rst_state == 2'd0)); // R9

endmodule

// File: tb/tb_sema_bank.sv
`timescale 1ns/100ps
module tb_sema_bank;
  localparam int NM = 4;
  localparam int NG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0]       wen, rsel;
  logic [NM-1:0][6:0]  addr;
  logic [NM-1:0][7:0]  wdata;
  logic [NM-1:0][1:0]  dom;
  logic [5:0]          rd_addr;
  logic [7:0]          rd_data;
  logic [1:0]          rst_state;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mg [NG];
  logic [1:0] mst;

  always #2 clk = ~clk;

  sema_bank #(.NUM_MASTERS(NM), .NUM_GATES(NG)) dut (
    .clk, .rst_n, .m_wen(wen), .m_rsel(rsel), .m_addr(addr),
    .m_wdata(wdata), .m_dom(dom), .rd_addr, .rd_data, .rst_state
  );

  task automatic idle();
    wen = '0; rsel = '0; addr = '0; wdata = '0; dom = '0;
  endtask

  task automatic put(input int m, input logic rs, input logic [6:0] a,
                     input logic [7:0] d, input logic [1:0] dm);
    wen[m] = 1'b1; rsel[m] = rs; addr[m] = a; wdata[m] = d; dom[m] = dm;
  endtask

  // reference: candidates in ascending master order against the old value,
  // forced clearing applied last
  task automatic model_apply();
    logic [7:0] old [NG];
    int  selm = -1;
    bit  anyw = 1'b0;
    bit  fire = 1'b0;
    for (int g = 0; g < NG; g++) old[g] = mg[g];
    for (int m = 0; m < NM; m++) begin
      if (wen[m]) anyw = 1'b1;
      if (wen[m] && rsel[m] && selm < 0) selm = m;
    end
    if (mst == 2'd0) begin
      if (selm >= 0 && wdata[selm] == 8'hE2) mst = 2'd1;
    end else begin
      if (selm >= 0 && wdata[selm] == 8'h1D) fire = 1'b1;
      if (anyw) mst = 2'd0;
    end
    for (int g = 0; g < NG; g++) begin
      bit done = 1'b0;
      for (int m = 0; m < NM; m++) begin
        if (!done && wen[m] && !rsel[m] && addr[m] == 7'(g)) begin
          if (old[g][3:0] == 4'd0 && wdata[m][3:0] == 4'(m + 1)) begin
            mg[g] = {2'b00, dom[m], 4'(m + 1)}; done = 1'b1;
          end else if (old[g][3:0] == 4'(m + 1) && wdata[m][3:0] == 4'd0) begin
            mg[g] = 8'h00; done = 1'b1;
          end
        end
      end
      if (fire && (addr[selm] >= 7'd64 || addr[selm] == 7'(g))) mg[g] = 8'h00;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_apply();
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_gate(input int g, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 6'(g);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic check_st(input logic [1:0] exp, input string tag);
    @(negedge clk);
    #1;
    chk(tag, {6'b0, rst_state}, {6'b0, exp});
  endtask

  task automatic check_all_model(input string tag);
    for (int g = 0; g < NG; g++) check_gate(g, mg[g], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rd_addr = '0;
    mst = 2'd0;
    for (int g = 0; g < NG; g++) mg[g] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    check_all_model("R1");
    check_gate(0, 8'h00, "R1");
    check_st(2'd0, "R1");

    // R2: master 1 claims gate 5 with domain 2
    @(negedge clk); put(1, 1'b0, 7'd5, 8'h02, 2'd2); step();
    check_gate(5, 8'h22, "R2");

    // R3: another master claims, then tries to free
    @(negedge clk); put(2, 1'b0, 7'd5, 8'h03, 2'd1); step();
    check_gate(5, 8'h22, "R3");
    @(negedge clk); put(2, 1'b0, 7'd5, 8'h00, 2'd1); step();
    check_gate(5, 8'h22, "R3");

    // R4 with R5: owner frees with junk in the upper nibble
    @(negedge clk); put(1, 1'b0, 7'd5, 8'hF0, 2'd2); step();
    check_gate(5, 8'h00, "R4");

    // R5: wrong owner field ignored; upper nibble ignored on a claim
    @(negedge clk); put(0, 1'b0, 7'd6, 8'h03, 2'd0); step();
    check_gate(6, 8'h00, "R5");
    @(negedge clk); put(0, 1'b0, 7'd6, 8'hA1, 2'd3); step();
    check_gate(6, 8'h31, "R5");

    // R6: race on a free gate, and release-plus-claim on an owned one
    @(negedge clk);
    put(3, 1'b0, 7'd9, 8'h04, 2'd2); put(2, 1'b0, 7'd9, 8'h03, 2'd1);
    step();
    check_gate(9, 8'h13, "R6");
    @(negedge clk);
    put(0, 1'b0, 7'd6, 8'h00, 2'd0); put(1, 1'b0, 7'd6, 8'h02, 2'd1);
    step();
    check_gate(6, 8'h00, "R6");

    // R7 / R9: single-gate forced release
    @(negedge clk); put(3, 1'b0, 7'd10, 8'h04, 2'd0); step();
    @(negedge clk); put(1, 1'b1, 7'd0, 8'hE2, 2'd0); step();
    check_st(2'd1, "R9");
    @(negedge clk); put(1, 1'b1, 7'd9, 8'h1D, 2'd0); step();
    check_gate(9, 8'h00, "R7");
    check_gate(10, 8'h04, "R7");
    check_st(2'd0, "R9");

    // R10: aborted sequences
    @(negedge clk); put(0, 1'b1, 7'd10, 8'hE2, 2'd0); step();
    @(negedge clk); put(0, 1'b1, 7'd10, 8'h1C, 2'd0); step();
    check_st(2'd0, "R10");
    check_gate(10, 8'h04, "R10");
    @(negedge clk); put(0, 1'b1, 7'd10, 8'hE2, 2'd0); step();
    @(negedge clk); put(2, 1'b0, 7'd20, 8'h03, 2'd0); step();
    check_st(2'd0, "R10");
    @(negedge clk); put(0, 1'b1, 7'd10, 8'h1D, 2'd0); step();
    check_gate(10, 8'h04, "R10");
    @(negedge clk); put(0, 1'b1, 7'd10, 8'hE2, 2'd0); step();
    @(negedge clk); put(0, 1'b1, 7'd10, 8'hE2, 2'd0); step();
    check_st(2'd0, "R10");

    // R11: completion collides with claims
    @(negedge clk); put(0, 1'b1, 7'd0, 8'hE2, 2'd0); step();
    @(negedge clk);
    put(0, 1'b1, 7'd11, 8'h1D, 2'd0);
    put(2, 1'b0, 7'd11, 8'h03, 2'd1);
    put(3, 1'b0, 7'd12, 8'h04, 2'd0);
    step();
    check_gate(11, 8'h00, "R11");
    check_gate(12, 8'h04, "R11");

    // R8: release every gate
    @(negedge clk); put(2, 1'b1, 7'd0, 8'hE2, 2'd0); step();
    @(negedge clk); put(2, 1'b1, 7'd100, 8'h1D, 2'd0); step();
    check_all_model("R8");
    check_gate(12, 8'h00, "R8");

    // R12: gate number out of range on a gate write
    @(negedge clk); put(1, 1'b0, 7'd70, 8'h02, 2'd1); step();
    check_gate(6, 8'h00, "R12");
    check_all_model("R12");

    // random traffic concentrated on a few gates
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int m = 0; m < NM; m++) begin
        if ($urandom % 3 == 0) begin
          if ($urandom % 20 == 0) begin
            int r = $urandom % 3;
            put(m, 1'b1, 7'($urandom % 128),
                (r == 0) ? 8'hE2 : (r == 1) ? 8'h1D : 8'($urandom), 2'($urandom));
          end else begin
            int r = $urandom % 4;
            logic [7:0] d;
            logic [6:0] a;
            a = ($urandom % 10 == 0) ? 7'($urandom % 128) : 7'($urandom % 8);
            case (r)
              0: d = 8'(m + 1);
              1: d = 8'h00;
              2: d = {4'($urandom), 4'(m + 1)};
              default: d = 8'($urandom);
            endcase
            put(m, 1'b0, a, d, 2'($urandom));
          end
        end
      end
      step();
      begin
        int g = ($urandom % 2 == 0) ? int'($urandom % 8) : int'($urandom % 64);
        check_gate(g, mg[g], "R6");
      end
      check_st(mst, "R9");
    end
    check_all_model("R2");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule